// File: doc/BRIEF.md
# Asynchronous SRAM timing controller

This block sits between a synchronous host and an external asynchronous static RAM. It runs one single-word read or write at a time. The host presents a request with a word address, write data, a per-byte lane mask and a direction flag. The block then produces the chip selects, the read-enable and write strobes, the active-low lane strobes, the write data bus and its drive enable. Every strobe and bus toward the memory comes straight from a flop, so no pin can glitch.

Every analog limit of the memory is a parameter in nanoseconds: address access, read cycle, write pulse, data-to-strobe-end, write cycle, write recovery and strobe-to-high-impedance. Elaboration turns each one into a cycle count for the clock period the block is given. Each phase of a transaction (setup, read wait, write pulse, recovery) counts down its own derived length. The host keeps its request held until a one-cycle ready pulse appears. For reads, the returned word is valid on that pulse.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, both selects are inactive (active-low select high, active-high select low), read enable and write strobe are high, all lane strobes are high, the data drive enable is low and ready is low.
- R2: A request whose lane mask is all zeros is not accepted. The selects stay inactive and ready never rises for as long as that request is held.
- R3: A read returns the stored word. The data is sampled no earlier than ceil(T_AA_NS/CLK_NS) cycles after the address and the selects were applied. Ready rises in the cycle after max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)) cycles, which is the 10th cycle after acceptance at the default parameters.
- R4: Lane strobe bit i (bit 0 = bits 7:0, bit 1 = bits 15:8) is low during a transaction exactly when mask bit i is 1. In the read result, lanes whose mask bit is 0 read as zero.
- R5: A write changes only the bytes whose mask bit is 1.
- R6: The write strobe stays low for at least max(T_WP_NS, T_DW_NS) of time. The write data is driven and unchanged for the whole of that time, and the address does not change while the strobe is low.
- R7: The read enable stays high throughout a write. The data drive enable never rises while the memory may still be driving: it stays off until at least T_WHZ_NS after the memory last had its read enable low with both selects active.
- R8: The write strobe returns high at least one cycle before the address can change. A write takes ceil(T_WHZ_NS/CLK_NS) + ceil(max(T_WP_NS,T_DW_NS)/CLK_NS) + 1 cycles up to ready (the 10th cycle at defaults), and this is never less than the write cycle time.
- R9: Ready is high for exactly one cycle per accepted request, and the selects are inactive in that cycle.
- R10: The write strobe is low only while both selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | LANES | Byte lane mask, bit 0 = low byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read result, valid with ready |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_sel_n_o | output | 1 | Chip select, active low |
| mem_sel_o | output | 1 | Chip select, active high |
| mem_rden_n_o | output | 1 | Memory read (output) enable, active low |
| mem_wr_n_o | output | 1 | Write strobe, active low |
| mem_lane_n_o | output | LANES | Byte lane strobes, active low |
| mem_wdata_o | output | DATA_W | Data toward the memory |
| mem_drive_o | output | 1 | Enable for the external data drivers |
| mem_rdata_i | input | DATA_W | Data from the memory |

## Verification
The bench connects a cycle-timed memory model. The model returns inverted bytes until the address-access time has passed, and it counts every strobe-width, data-window, address-hold and bus-contention error. A table of writes and reads goes through full-word, low-only and high-only masks at both ends of the address range. Reads with partial masks show whether lane masking and byte merging are correct, and a read that follows a write to the same word shows whether the data is sampled too early. Read-to-write alternation in the table tests the turnaround delay. Directed cases cover reset, an all-zero mask and reset in the middle of a write.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SETUP    = 3'd1,
      ST_RD_WAIT  = 3'd2,
      ST_WR_PULSE = 3'd3,
      ST_RECOVER  = 3'd4
   } asram_state_e;

   // round a nanosecond limit up to whole clock periods
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // a - b, floored at zero
   function automatic int unsigned sub_sat(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : 0;
   endfunction

endpackage

// File: rtl/asram_delay_cnt.sv
`timescale 1ns/1ps
module asram_delay_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
   import asram_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int RD_SETUP = 1,
   parameter int RD_WAIT  = 8,
   parameter int RD_REC   = 1,
   parameter int WR_SETUP = 4,
   parameter int WR_PULSE = 5,
   parameter int WR_REC   = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         write_i,
   output asram_state_e nxt_o,
   output logic         accept_o,
   output logic         capture_o,
   output logic         done_o
);

   localparam logic [CNT_W-1:0] L_RS = CNT_W'(RD_SETUP - 1);
   localparam logic [CNT_W-1:0] L_RW = CNT_W'(RD_WAIT - 1);
   localparam logic [CNT_W-1:0] L_RR = CNT_W'(RD_REC - 1);
   localparam logic [CNT_W-1:0] L_WS = CNT_W'(WR_SETUP - 1);
   localparam logic [CNT_W-1:0] L_WP = CNT_W'(WR_PULSE - 1);
   localparam logic [CNT_W-1:0] L_WR = CNT_W'(WR_REC - 1);

   asram_state_e     state_q, nxt;
   logic             wr_q;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             zero;

   asram_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .zero_o     (zero)
   );

   always_comb begin
      nxt      = state_q;
      load     = 1'b0;
      load_val = '0;
      accept_o = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               nxt      = ST_SETUP;
               accept_o = 1'b1;
               load     = 1'b1;
               load_val = write_i ? L_WS : L_RS;
            end
         end
         ST_SETUP: begin
            if (zero) begin
               load = 1'b1;
               if (wr_q) begin
                  nxt      = ST_WR_PULSE;
                  load_val = L_WP;
               end else begin
                  nxt      = ST_RD_WAIT;
                  load_val = L_RW;
               end
            end
         end
         ST_RD_WAIT: begin
            if (zero) begin
               nxt      = ST_RECOVER;
               load     = 1'b1;
               load_val = L_RR;
            end
         end
         ST_WR_PULSE: begin
            if (zero) begin
               nxt      = ST_RECOVER;
               load     = 1'b1;
               load_val = L_WR;
            end
         end
         ST_RECOVER: begin
            if (zero)
               nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= nxt;
         if (accept_o)
            wr_q <= write_i;
      end
   end

   assign nxt_o     = nxt;
   assign capture_o = (state_q == ST_RD_WAIT) && zero;
   assign done_o    = (state_q == ST_RECOVER) && zero;

endmodule

// File: rtl/asram_pin_drv.sv
`timescale 1ns/1ps
module asram_pin_drv
   import asram_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  asram_state_e      nxt_i,
   input  logic              accept_i,
   input  logic              capture_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [LANES-1:0]  req_be_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_sel_n_o,
   output logic              mem_sel_o,
   output logic              mem_rden_n_o,
   output logic              mem_wr_n_o,
   output logic [LANES-1:0]  mem_lane_n_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_drive_o
);

   localparam int LANE_W = DATA_W / LANES;

   logic              wr_q, wr_nx;
   logic [LANES-1:0]  be_q, be_nx;
   logic [LANES-1:0]  lane_nx;
   logic [DATA_W-1:0] rd_nx;
   logic              sel_act, rd_act, drv_act;

   assign wr_nx   = accept_i ? req_write_i : wr_q;
   assign be_nx   = accept_i ? req_be_i    : be_q;
   assign sel_act = (nxt_i == ST_SETUP) || (nxt_i == ST_RD_WAIT) || (nxt_i == ST_WR_PULSE);
   assign rd_act  = !wr_nx && ((nxt_i == ST_SETUP) || (nxt_i == ST_RD_WAIT));
   // data stays driven through recovery so the hold after the strobe rises is positive
   assign drv_act = wr_nx && ((nxt_i == ST_WR_PULSE) || (nxt_i == ST_RECOVER));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_nx[g] = !(sel_act && be_nx[g]);
      assign rd_nx[g*LANE_W +: LANE_W] =
         be_q[g] ? mem_rdata_i[g*LANE_W +: LANE_W] : {LANE_W{1'b0}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q         <= 1'b0;
         be_q         <= '0;
         rdata_o      <= '0;
         mem_addr_o   <= '0;
         mem_wdata_o  <= '0;
         mem_sel_n_o  <= 1'b1;
         mem_sel_o    <= 1'b0;
         mem_rden_n_o <= 1'b1;
         mem_wr_n_o   <= 1'b1;
         mem_lane_n_o <= '1;
         mem_drive_o  <= 1'b0;
      end else begin
         wr_q <= wr_nx;
         be_q <= be_nx;
         if (accept_i) begin
            mem_addr_o  <= req_addr_i;
            mem_wdata_o <= req_wdata_i;
         end
         if (capture_i)
            rdata_o <= rd_nx;
         mem_sel_n_o  <= !sel_act;
         mem_sel_o    <= sel_act;
         mem_rden_n_o <= !rd_act;
         mem_wr_n_o   <= !(nxt_i == ST_WR_PULSE);
         mem_lane_n_o <= lane_nx;
         mem_drive_o  <= drv_act;
      end
   end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 16,
   parameter int LANES    = 2,
   parameter int CLK_NS   = 8,
   parameter int T_AA_NS  = 70,
   parameter int T_RC_NS  = 70,
   parameter int T_WC_NS  = 70,
   parameter int T_WP_NS  = 35,
   parameter int T_DW_NS  = 30,
   parameter int T_WR_NS  = 0,
   parameter int T_WHZ_NS = 30,
   parameter int CNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [LANES-1:0]  req_be_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_sel_n_o,
   output logic              mem_sel_o,
   output logic              mem_rden_n_o,
   output logic              mem_wr_n_o,
   output logic [LANES-1:0]  mem_lane_n_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_drive_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);

   // cycle counts derived from the nanosecond limits
   localparam int AA_CYC   = int'(max_u(1, ns_to_cyc(T_AA_NS, CLK_NS)));
   localparam int RC_CYC   = int'(ns_to_cyc(T_RC_NS, CLK_NS));
   localparam int WC_CYC   = int'(ns_to_cyc(T_WC_NS, CLK_NS));
   localparam int RD_SETUP = 1;
   localparam int RD_WAIT  = int'(max_u(1, AA_CYC - 1));
   localparam int RD_REC   = int'(max_u(1, sub_sat(RC_CYC, RD_SETUP + RD_WAIT)));
   localparam int WR_SETUP = int'(max_u(1, ns_to_cyc(T_WHZ_NS, CLK_NS)));
   localparam int WR_PULSE = int'(max_u(1, max_u(ns_to_cyc(T_WP_NS, CLK_NS),
                                                 ns_to_cyc(T_DW_NS, CLK_NS))));
   localparam int WR_REC   = int'(max_u(max_u(1, ns_to_cyc(T_WR_NS, CLK_NS)),
                                        sub_sat(WC_CYC, WR_SETUP + WR_PULSE)));
   localparam int LONGEST  = int'(max_u(max_u(RD_WAIT, RD_REC),
                                        max_u(max_u(WR_SETUP, WR_PULSE), WR_REC)));

   if (DATA_W != LANES * 8) begin : g_bad_width
      $error("asram_ctrl: DATA_W must be 8 bits per lane");
   end
   if (LONGEST > (1 << CNT_W)) begin : g_bad_cnt
      $error("asram_ctrl: CNT_W too narrow for derived delays");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("asram_ctrl: CLK_NS must be positive");
   end

   asram_state_e nxt;
   logic         accept, capture;
   logic         start;

   assign start = req_i && (req_be_i != '0);

   asram_seq #(
      .CNT_W    (CNT_W),
      .RD_SETUP (RD_SETUP),
      .RD_WAIT  (RD_WAIT),
      .RD_REC   (RD_REC),
      .WR_SETUP (WR_SETUP),
      .WR_PULSE (WR_PULSE),
      .WR_REC   (WR_REC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .write_i   (req_write_i),
      .nxt_o     (nxt),
      .accept_o  (accept),
      .capture_o (capture),
      .done_o    (ready_o)
   );

   asram_pin_drv #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_pins (
      .clk          (clk),
      .rst_n        (rst_n),
      .nxt_i        (nxt),
      .accept_i     (accept),
      .capture_i    (capture),
      .req_write_i  (req_write_i),
      .req_addr_i   (req_addr_i),
      .req_wdata_i  (req_wdata_i),
      .req_be_i     (req_be_i),
      .mem_rdata_i  (mem_rdata_i),
      .rdata_o      (rdata_o),
      .mem_addr_o   (mem_addr_o),
      .mem_sel_n_o  (mem_sel_n_o),
      .mem_sel_o    (mem_sel_o),
      .mem_rden_n_o (mem_rden_n_o),
      .mem_wr_n_o   (mem_wr_n_o),
      .mem_lane_n_o (mem_lane_n_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_drive_o  (mem_drive_o)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
   parameter int ADDR_W  = 18,
   parameter int LANES   = 2,
   parameter int CLK_NS  = 8,
   parameter int T_WP_NS = 35
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [LANES-1:0]  req_be_i,
   input logic              ready_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_sel_n_o,
   input logic              mem_sel_o,
   input logic              mem_rden_n_o,
   input logic              mem_wr_n_o,
   input logic [LANES-1:0]  mem_lane_n_o,
   input logic              mem_drive_o
);

   logic [15:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_len <= '0;
      else if (!mem_wr_n_o)
         low_len <= low_len + 1'b1;
      else
         low_len <= '0;
   end

   // R2
   zero_mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel_n_o && req_i && req_be_i == '0) |=> mem_sel_n_o);

   // R4
   lane_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_sel_n_o |-> (mem_lane_n_o != '1));

   // R6
   strobe_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n_o |-> $stable(mem_addr_o));

   // R6
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n_o) |-> (int'(low_len) * CLK_NS >= T_WP_NS));

   // R7
   no_drive_while_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_drive_o |-> mem_rden_n_o);

   // R7
   read_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n_o |-> mem_rden_n_o);

   // R8
   release_before_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n_o) |-> $stable(mem_addr_o));

   // R9
   ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o);

   // R9
   ready_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (mem_sel_n_o && !mem_sel_o));

   // R10
   strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n_o |-> (!mem_sel_n_o && mem_sel_o));

endmodule

bind asram_ctrl asram_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .LANES   (LANES),
   .CLK_NS  (CLK_NS),
   .T_WP_NS (T_WP_NS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .req_be_i     (req_be_i),
   .ready_o      (ready_o),
   .mem_addr_o   (mem_addr_o),
   .mem_sel_n_o  (mem_sel_n_o),
   .mem_sel_o    (mem_sel_o),
   .mem_rden_n_o (mem_rden_n_o),
   .mem_wr_n_o   (mem_wr_n_o),
   .mem_lane_n_o (mem_lane_n_o),
   .mem_drive_o  (mem_drive_o)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

   localparam int CLK_NS   = 8;
   localparam int T_AA_NS  = 70;
   localparam int T_WP_NS  = 35;
   localparam int T_DW_NS  = 30;
   localparam int T_WHZ_NS = 30;
   localparam int EXP_LAT  = 10;
   localparam int NVEC     = 11;

   // {write, mask[1:0], addr[17:0], data or expected read[15:0]}
   localparam logic [36:0] VEC [NVEC] = '{
      {1'b1, 2'b11, 18'h00010, 16'hA55A},
      {1'b1, 2'b11, 18'h3FFFF, 16'h1234},
      {1'b0, 2'b11, 18'h00010, 16'hA55A},
      {1'b1, 2'b01, 18'h00010, 16'hFFC3},
      {1'b0, 2'b11, 18'h00010, 16'hA5C3},
      {1'b1, 2'b10, 18'h3FFFF, 16'h77EE},
      {1'b0, 2'b10, 18'h3FFFF, 16'h7700},
      {1'b0, 2'b01, 18'h3FFFF, 16'h0034},
      {1'b0, 2'b11, 18'h3FFFF, 16'h7734},
      {1'b1, 2'b11, 18'h00000, 16'h0000},
      {1'b0, 2'b11, 18'h00000, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        ready;
   logic [15:0] rdata;
   logic [17:0] m_addr;
   logic        m_sel_n, m_sel, m_rden_n, m_wr_n, m_drive;
   logic [1:0]  m_lane_n;
   logic [15:0] m_wdata;
   logic [15:0] m_rdata = 16'h0BAD;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   asram_ctrl u_asram_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .req_write_i  (req_write),
      .req_addr_i   (req_addr),
      .req_wdata_i  (req_wdata),
      .req_be_i     (req_be),
      .ready_o      (ready),
      .rdata_o      (rdata),
      .mem_addr_o   (m_addr),
      .mem_sel_n_o  (m_sel_n),
      .mem_sel_o    (m_sel),
      .mem_rden_n_o (m_rden_n),
      .mem_wr_n_o   (m_wr_n),
      .mem_lane_n_o (m_lane_n),
      .mem_wdata_o  (m_wdata),
      .mem_drive_o  (m_drive),
      .mem_rdata_i  (m_rdata)
   );

   // ---------------- cycle-timed memory model ----------------
   logic [15:0] mem_arr [256];
   logic [17:0] prev_addr = '0;
   bit          prev_act = 1'b0, prev_drives = 1'b0, prev_wr_low = 1'b0;
   int          addr_age = 0, rel_age = 1000, pulse_cnt = 0, dw_cnt = 0;
   logic [15:0] pend_data = '0, prev_wdata = '0;
   logic [1:0]  pend_lane = '0;
   logic [7:0]  pend_idx = '0;
   int v_addr = 0, v_pulse = 0, v_dw = 0, v_turn = 0, v_lane = 0, v_sel = 0, v_rden = 0;

   initial begin
      for (int i = 0; i < 256; i++) mem_arr[i] = 16'hFFFF;
   end

   always @(negedge clk) begin
      bit sel_on, drives, act;
      if (!rst_n) begin
         prev_act = 1'b0; prev_drives = 1'b0; prev_wr_low = 1'b0;
         pulse_cnt = 0; dw_cnt = 0; rel_age = 1000; addr_age = 0;
         prev_addr = m_addr;
         m_rdata <= 16'h0BAD;
      end else begin
         sel_on = !m_sel_n && m_sel;
         drives = sel_on && !m_rden_n && m_wr_n;
         act    = sel_on && !m_wr_n;
         if (m_addr != prev_addr && (!m_wr_n || prev_wr_low)) v_addr++;
         if (!m_wr_n && !sel_on) v_sel++;
         if (sel_on && m_lane_n == 2'b11) v_lane++;
         if (act && !m_rden_n) v_rden++;
         if (act) begin
            pulse_cnt++;
            if (m_drive && (pulse_cnt == 1 || m_wdata == prev_wdata)) dw_cnt++;
            else dw_cnt = 0;
            pend_data = m_wdata; pend_lane = ~m_lane_n; pend_idx = m_addr[7:0];
         end else if (prev_act) begin
            if (pulse_cnt * CLK_NS < T_WP_NS) v_pulse++;
            if (dw_cnt * CLK_NS < T_DW_NS) v_dw++;
            if (pend_lane[0]) mem_arr[pend_idx][7:0]  = pend_data[7:0];
            if (pend_lane[1]) mem_arr[pend_idx][15:8] = pend_data[15:8];
            pulse_cnt = 0; dw_cnt = 0;
         end
         if (m_drive && (drives || rel_age * CLK_NS - CLK_NS / 2 < T_WHZ_NS)) v_turn++;
         if (drives) rel_age = 0; else if (rel_age < 1000) rel_age++;
         if (m_addr != prev_addr || !prev_drives) addr_age = 0; else addr_age++;
         if (drives) begin
            for (int g = 0; g < 2; g++) begin
               if (!m_lane_n[g] && (addr_age + 1) * CLK_NS >= T_AA_NS)
                  m_rdata[g*8 +: 8] <= mem_arr[m_addr[7:0]][g*8 +: 8];
               else
                  m_rdata[g*8 +: 8] <= ~mem_arr[m_addr[7:0]][g*8 +: 8];
            end
         end else begin
            m_rdata <= 16'h0BAD;
         end
         prev_addr = m_addr; prev_act = act; prev_drives = drives;
         prev_wr_low = !m_wr_n; prev_wdata = m_wdata;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [6:0] pins_now();
      return {m_sel_n, m_sel, m_rden_n, m_wr_n, m_lane_n, m_drive};
   endfunction

   localparam logic [6:0] PINS_IDLE = 7'b1011110;

   task automatic run_op(input logic w, input logic [1:0] be, input logic [17:0] a,
                         input logic [15:0] d, output int lat, output logic [15:0] rd);
      req_write = w; req_be = be; req_addr = a; req_wdata = d; req = 1'b1;
      lat = 0;
      rd  = '0;
      while (lat < 100) begin
         @(negedge clk);
         lat++;
         if (ready) begin
            rd = rdata;
            break;
         end
      end
      req = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         fails++; tests++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int lat;
      logic [15:0] rd;
      int seen;
      repeat (3) @(negedge clk);
      // R1: levels under reset
      chk(pins_now() == PINS_IDLE && !ready, "R1 pins in reset", pins_now(), PINS_IDLE);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(pins_now() == PINS_IDLE && !ready, "R1 pins after reset", pins_now(), PINS_IDLE);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][36], VEC[i][35:34], VEC[i][33:16], VEC[i][15:0], lat, rd);
         if (VEC[i][36]) chk(lat == EXP_LAT, "R8 write latency", lat, EXP_LAT);
         else            chk(lat == EXP_LAT, "R3 read latency", lat, EXP_LAT);
         if (!VEC[i][36]) chk(rd == VEC[i][15:0], "R3 R4 R5 read data", rd, VEC[i][15:0]);
         @(negedge clk);
         chk(!ready, "R9 ready one cycle", ready, 0);
      end

      // R2: all-zero mask held for a while
      req_write = 1'b1; req_be = 2'b00; req_addr = 18'h00020; req_wdata = 16'h5555; req = 1'b1;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (!m_sel_n || m_sel || ready) seen++;
      end
      req = 1'b0;
      chk(seen == 0, "R2 zero mask ignored", seen, 0);
      run_op(1'b0, 2'b11, 18'h00020, 16'h0, lat, rd);
      chk(rd == 16'hFFFF, "R2 zero mask wrote nothing", rd, 16'hFFFF);

      // R1: reset while a write is being set up
      req_write = 1'b1; req_be = 2'b11; req_addr = 18'h00030; req_wdata = 16'h1111; req = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(pins_now() == PINS_IDLE && !ready, "R1 reset mid write", pins_now(), PINS_IDLE);
      req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(1'b0, 2'b11, 18'h00030, 16'h0, lat, rd);
      chk(rd == 16'hFFFF, "R1 aborted write left memory", rd, 16'hFFFF);
      chk(lat == EXP_LAT, "R3 read after reset latency", lat, EXP_LAT);

      // model counters
      chk(v_pulse == 0, "R6 strobe width", v_pulse, 0);
      chk(v_dw == 0, "R6 data window", v_dw, 0);
      chk(v_turn == 0, "R7 bus turnaround", v_turn, 0);
      chk(v_rden == 0, "R7 read enable in write", v_rden, 0);
      chk(v_addr == 0, "R8 address held around strobe", v_addr, 0);
      chk(v_lane == 0, "R4 lane strobes", v_lane, 0);
      chk(v_sel == 0, "R10 strobe without select", v_sel, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule